// File: doc/BRIEF.md
# Cascaded-Integrator Sigma-Delta Modulator

This block turns a signed parallel sample into a one-bit oversampled stream. It uses a chain of integrators. The single output bit is turned into a full-scale feedback value, scaled by a per-stage coefficient, and subtracted at the input of every integrator. The coefficients are fixed parameters. They are chosen off-line so that the signal transfer function of the loop matches a wanted all-pole response.

A global right shift is applied to every stage increment. Each extra step of shift lowers the loop gain by a factor of two, and this is how a loop that is unstable at one setting is brought back into range. A clock enable lets the loop advance at a rate below the clock. In normal use the enable is held high. The integrators carry guard bits above the input width. When the loop is driven beyond its range, they clamp at their limits instead of wrapping.

Top module: `sdm_cascade`

## Requirements
- R1: The reset is synchronous and active low. While `rst_n` is 0 at a clock edge, every integrator is cleared to zero and `bit_out` becomes 0, whatever `adv_en` is.
- R2: At a clock edge where `adv_en` is 0, neither `bit_out` nor any integrator changes, whatever `sample_in` is. After the enable returns, the stream continues exactly as if those cycles had not occurred.
- R3: Each integrator saturates to the most positive or most negative value its width can hold, and never wraps.
- R4: At each enabled edge, `bit_out` is loaded with 1 when the last integrator value before that edge is greater than or equal to zero, and with 0 otherwise. So the first enabled edge after reset yields 1.
- R5: The feedback for stage k is +COEF[k]·2^(WIDTH-1) when `bit_out` is 1 and −COEF[k]·2^(WIDTH-1) when it is 0.
- R6: The increment of each stage is (stage input − stage feedback) shifted right arithmetically by SHIFT bits, which rounds toward minus infinity.
- R7: Stage 0 takes `sample_in` as its input. Stage k>0 takes the value stage k−1 held before the edge. All stages and the output bit update on the same enabled edge.
- R8: Each integrator is WIDTH+GUARD bits wide, two's complement, and its limits are ±2^(WIDTH+GUARD−1) (the positive limit minus one).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_en | input | 1 | Loop advance enable |
| sample_in | input | WIDTH | Signed input sample |
| bit_out | output | 1 | One-bit modulated stream |

## Verification
The hardest state to reach from the ports is integrator saturation. With the default guard bits and coefficients, a loop in range never gets near its limits. The bench therefore also builds an instance with a single guard bit, no shift and unit coefficients, which is unstable. It then holds a full-scale input on it for hundreds of cycles, so that every stage pins at its limit. A bit-exact bench model tracks the same clamps and records that they were reached. A second instance with a larger shift is also compared. Random enable gaps check that state is frozen in between.

// File: rtl/sdm_pkg.sv
// Package: shared constants and width helpers for the sigma-delta cascade.
// Assumes coefficients are non-negative integers below 2**COEF_BITS.
package sdm_pkg;

    // Bits reserved for a feedback coefficient magnitude
    localparam int COEF_BITS = 8;

    // Width of the per-stage difference path, wide enough for
    // accumulator value minus the largest scaled feedback term.
    function automatic int diff_width(input int acc_w);
        return acc_w + COEF_BITS + 1;
    endfunction

endpackage

// File: rtl/sdm_feedback.sv
// Module: sdm_feedback
// Maps the output bit to a signed feedback value of +/- COEF * 2**(WIDTH-1).
// Assumes COEF * 2**(WIDTH-1) fits in DIFF_W-1 bits.
module sdm_feedback #(
    parameter int WIDTH  = 16,
    parameter int DIFF_W = 33,
    parameter int COEF   = 1
) (
    input  logic                     bit_q,
    output logic signed [DIFF_W-1:0] fb_val
);

    localparam logic signed [DIFF_W-1:0] COEF_EXT = DIFF_W'(COEF);
    localparam logic signed [DIFF_W-1:0] MAG      = COEF_EXT <<< (WIDTH - 1);

    // Select the positive or negative full-scale term from the bit
    always_comb begin
        fb_val = bit_q ? MAG : -MAG;
    end

endmodule

// File: rtl/sdm_integrator.sv
// Module: sdm_integrator
// One saturating integrator stage. On each enabled edge it adds the
// arithmetically right-shifted difference to its accumulator and clamps
// the result to the signed ACC_W range.
// Assumes DIFF_W > ACC_W and that the difference fits in DIFF_W-1 bits.
module sdm_integrator #(
    parameter int ACC_W  = 24,
    parameter int DIFF_W = 33,
    parameter int SHIFT  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv_en,
    input  logic signed [DIFF_W-1:0] diff_in,
    output logic signed [ACC_W-1:0]  acc_q
);

    localparam int EXT = DIFF_W - ACC_W;
    localparam logic signed [DIFF_W-1:0] HI_LIM =
        {{(EXT + 1){1'b0}}, {(ACC_W - 1){1'b1}}};
    localparam logic signed [DIFF_W-1:0] LO_LIM =
        {{(EXT + 1){1'b1}}, {(ACC_W - 1){1'b0}}};

    logic signed [DIFF_W-1:0] step;
    logic signed [DIFF_W-1:0] acc_ext;
    logic signed [DIFF_W-1:0] total;
    logic signed [ACC_W-1:0]  acc_next;

    // Scale the difference and form the unclamped new sum
    always_comb begin
        step    = diff_in >>> SHIFT;
        acc_ext = {{EXT{acc_q[ACC_W-1]}}, acc_q};
        total   = acc_ext + step;
    end

    // Clamp the sum to the accumulator range
    always_comb begin
        if (total > HI_LIM) begin
            acc_next = HI_LIM[ACC_W-1:0];
        end else if (total < LO_LIM) begin
            acc_next = LO_LIM[ACC_W-1:0];
        end else begin
            acc_next = total[ACC_W-1:0];
        end
    end

    // Accumulator register with synchronous clear and enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (adv_en) begin
            acc_q <= acc_next;
        end
    end

    AST_FROZEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_en |=> $stable(acc_q)); // R2

    AST_NO_WRAP_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && acc_q >= 0 && step >= 0) |=> acc_q >= 0); // R3

    AST_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && acc_q < 0 && step < 0) |=> acc_q < 0); // R3

endmodule

// File: rtl/sdm_quantizer.sv
// Module: sdm_quantizer
// One-bit comparator with an output register. It loads 1 when the last
// integrator is >= 0 and 0 otherwise, using the value before the edge.
// Assumes the accumulator input is two's complement.
module sdm_quantizer #(
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv_en,
    input  logic signed [ACC_W-1:0] acc_in,
    output logic                    bit_q
);

    logic non_neg;

    // Sign test of the final integrator
    always_comb begin
        non_neg = (acc_in >= 0);
    end

    // Output bit register with synchronous clear and enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else if (adv_en) begin
            bit_q <= non_neg;
        end
    end

    AST_SIGN_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en |=> bit_q == ($past(acc_in) >= 0)); // R4

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_en |=> $stable(bit_q)); // R2

    AST_RESET_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !bit_q); // R1

endmodule

// File: rtl/sdm_cascade.sv
// Module: sdm_cascade (top)
// A cascade of STAGES saturating integrators with distributed feedback
// from a one-bit quantizer. Stage 0 integrates the input sample. Each
// later stage integrates the previous stage's accumulator. All stages
// subtract COEF[k] times the full-scale feedback.
// Assumes 0 <= COEF[k] < 2**COEF_BITS and GUARD >= 1.
module sdm_cascade
    import sdm_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int STAGES = 4,
    parameter int GUARD  = 8,
    parameter int SHIFT  = 2,
    parameter int COEF [STAGES] = '{1, 2, 2, 1}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv_en,
    input  logic signed [WIDTH-1:0] sample_in,
    output logic                    bit_out
);

    localparam int ACC_W  = WIDTH + GUARD;
    localparam int DIFF_W = diff_width(ACC_W);

    logic signed [ACC_W-1:0]  acc  [STAGES];
    logic signed [DIFF_W-1:0] src  [STAGES];
    logic signed [DIFF_W-1:0] fb   [STAGES];
    logic signed [DIFF_W-1:0] diff [STAGES];

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_stage
            // Select the stage input: the sample for stage 0, otherwise the previous accumulator
            if (k == 0) begin : g_first
                always_comb begin
                    src[k] = {{(DIFF_W - WIDTH){sample_in[WIDTH-1]}}, sample_in};
                end
            end else begin : g_chain
                always_comb begin
                    src[k] = {{(DIFF_W - ACC_W){acc[k-1][ACC_W-1]}}, acc[k-1]};
                end
            end

            sdm_feedback #(
                .WIDTH  (WIDTH),
                .DIFF_W (DIFF_W),
                .COEF   (COEF[k])
            ) u_fb (
                .bit_q  (bit_out),
                .fb_val (fb[k])
            );

            // Difference between the stage input and its feedback term
            always_comb begin
                diff[k] = src[k] - fb[k];
            end

            sdm_integrator #(
                .ACC_W  (ACC_W),
                .DIFF_W (DIFF_W),
                .SHIFT  (SHIFT)
            ) u_int (
                .clk     (clk),
                .rst_n   (rst_n),
                .adv_en  (adv_en),
                .diff_in (diff[k]),
                .acc_q   (acc[k])
            );
        end
    endgenerate

    sdm_quantizer #(
        .ACC_W (ACC_W)
    ) u_q (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_en (adv_en),
        .acc_in (acc[STAGES-1]),
        .bit_q  (bit_out)
    );

    AST_RESET_CLEARS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> acc[0] == 0); // R1

    AST_FIRST_STAGE_FOLLOWS_FB: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && bit_out && sample_in < 0 && acc[0] <= 0) |=> acc[0] < 0); // R5

endmodule

// File: tb/sdm_cascade_test.sv
// Bench for sdm_cascade: three instances with different settings are
// compared bit by bit against a behavioural model computed here.
module sdm_cascade_test;

    localparam int W  = 16;
    localparam int N  = 4;
    localparam longint FS = longint'(1) <<< (W - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adv_en = 1'b0;
    logic signed [W-1:0] sample_in = '0;
    logic out_a, out_b, out_c;

    int checks = 0;
    int fails  = 0;
    bit sat_hit = 1'b0;

    longint st_a [N];
    longint st_b [N];
    longint st_c [N];
    bit y_a, y_b, y_c;
    longint cf_a [N] = '{1, 2, 2, 1};
    longint cf_c [N] = '{1, 1, 1, 1};

    always #2 clk = ~clk;

    sdm_cascade #(.WIDTH(W), .STAGES(N), .GUARD(8), .SHIFT(2),
                  .COEF('{1, 2, 2, 1})) uut (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en),
        .sample_in(sample_in), .bit_out(out_a));

    sdm_cascade #(.WIDTH(W), .STAGES(N), .GUARD(8), .SHIFT(4),
                  .COEF('{1, 2, 2, 1})) uut_shift (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en),
        .sample_in(sample_in), .bit_out(out_b));

    sdm_cascade #(.WIDTH(W), .STAGES(N), .GUARD(1), .SHIFT(0),
                  .COEF('{1, 1, 1, 1})) uut_sat (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en),
        .sample_in(sample_in), .bit_out(out_c));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model of one enabled edge (R4 R5 R6 R7 R8 R3)
    task automatic model_step(ref longint st[N], ref bit y, input longint x,
                              input int sh, input int aw, ref longint cf[N], input bit track);
        longint old [N];
        longint hi, lo, u, d, n;
        hi = (longint'(1) <<< (aw - 1)) - 1;
        lo = -(longint'(1) <<< (aw - 1));
        for (int k = 0; k < N; k++) old[k] = st[k];
        for (int k = 0; k < N; k++) begin
            u = (k == 0) ? x : old[k-1];
            d = (u - (y ? cf[k] * FS : -cf[k] * FS)) >>> sh;
            n = old[k] + d;
            if (n > hi) begin n = hi; if (track) sat_hit = 1'b1; end
            if (n < lo) begin n = lo; if (track) sat_hit = 1'b1; end
            st[k] = n;
        end
        y = (old[N-1] >= 0);
    endtask

    task automatic model_reset();
        for (int k = 0; k < N; k++) begin
            st_a[k] = 0; st_b[k] = 0; st_c[k] = 0;
        end
        y_a = 1'b0; y_b = 1'b0; y_c = 1'b0;
    endtask

    // One clock: drive at negedge, update the model, sample after the edge
    task automatic cyc(input longint x, input bit e, input bit r);
        @(negedge clk);
        sample_in = W'(x);
        adv_en = e;
        rst_n = r;
        @(posedge clk);
        #1;
        if (!r) begin
            model_reset();
        end else if (e) begin
            model_step(st_a, y_a, x, 2, W + 8, cf_a, 1'b0);
            model_step(st_b, y_b, x, 4, W + 8, cf_a, 1'b0);
            model_step(st_c, y_c, x, 0, W + 1, cf_c, 1'b1);
        end
        check(out_a == y_a, "R7 R5 stream", longint'(out_a), longint'(y_a));
        check(out_b == y_b, "R6 shifted stream", longint'(out_b), longint'(y_b));
        check(out_c == y_c, "R3 R8 saturating stream", longint'(out_c), longint'(y_c));
    endtask

    function automatic longint rnd_sample();
        return longint'($signed(16'($urandom)));
    endfunction

    initial begin
        #(4 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit held;
        void'($urandom(32'd4242));
        model_reset();

        // R1: reset state, enable high during reset must not matter
        for (int i = 0; i < 3; i++) cyc(rnd_sample(), 1'b1, 1'b0);
        check(out_a == 1'b0, "R1 reset output", longint'(out_a), 0);

        // R4: first enabled edge after reset gives 1
        cyc(0, 1'b1, 1'b1);
        check(out_a == 1'b1, "R4 first decision", longint'(out_a), 1);

        // R5 R7: zero input
        for (int i = 0; i < 40; i++) cyc(0, 1'b1, 1'b1);

        // R2: enable low with wild input, output held
        held = out_a;
        for (int i = 0; i < 25; i++) begin
            cyc(rnd_sample(), 1'b0, 1'b1);
            check(out_a == held, "R2 hold while disabled", longint'(out_a), longint'(held));
        end
        for (int i = 0; i < 30; i++) cyc(1000, 1'b1, 1'b1);

        // R3: full-scale extremes drive the unstable instance into its limits
        for (int i = 0; i < 300; i++) cyc(FS - 1, 1'b1, 1'b1);
        for (int i = 0; i < 300; i++) cyc(-FS, 1'b1, 1'b1);
        check(sat_hit, "R3 saturation reached", longint'(sat_hit), 1);

        // Random samples with random enable gaps (R2 R6 R7)
        for (int i = 0; i < 3000; i++)
            cyc(rnd_sample() >>> ($urandom % 4), ($urandom % 4) != 0, 1'b1);

        // R1: mid-stream reset clears all state
        cyc(rnd_sample(), 1'b1, 1'b0);
        cyc(rnd_sample(), 1'b0, 1'b0);
        check(out_a == 1'b0, "R1 mid-stream reset", longint'(out_a), 0);
        for (int i = 0; i < 200; i++) cyc(rnd_sample(), 1'b1, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule